// File: doc/BRIEF.md
# Four-Sample Fixed-Point Rate Estimator

This block estimates the rate of change of a signed fixed-point signal that arrives as a sample strobe together with a sample period value. Each sample accepted while the run input is high is pushed into a four-deep history. The block then forms a noise-reducing weighted difference of the newest sample and its three predecessors. That difference is divided by ten times the period in a signed sequential divider. The quotient appears on the rate output with a one-cycle valid pulse.

The divider needs a fixed number of cycles, equal to the output width. A strobe that arrives while it is working is dropped and sets a sticky overrun flag. A period of zero starts no division and raises an error flag instead. While run is low, strobes are ignored and the history is held at zero, so the first three results after enabling are formed from zero-filled history entries.

Top module: `deriv_rate_top`

## Requirements
- R1: For an accepted sample x0 with previous accepted samples x1, x2, x3 (newest first), the rate output becomes (3*(x0-x3) + x1 - x2) / (10*period), where period is the value on period_in at the strobe.
- R2: The division is signed and truncates toward zero. For example, a numerator of -27 with period 1 gives -2.
- R3: rate_valid goes high exactly OUT_W clock cycles after the edge that accepts the strobe, and stays high for a single cycle. rate_out changes only at the edge that raises rate_valid. busy is high from the accept edge until rate_valid rises.
- R4: While run is low, sample strobes are ignored: no division starts, rate_valid stays low, rate_out holds and busy stays low.
- R5: After reset, and for as long as run is low, all three history entries read as zero. The first results after run rises are therefore computed with zeros in place of the missing samples.
- R6: A strobe that arrives with run high while busy is high is ignored and does not enter the history. It sets overrun, which then stays high until reset.
- R7: An accepted strobe with period_in equal to 0 still shifts its sample into the history. It starts no division, produces no rate_valid, leaves rate_out unchanged and sets zero_err. zero_err clears at the next accepted strobe whose period is nonzero.
- R8: After reset, rate_out is 0, and rate_valid, busy, overrun and zero_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables sampling; while low, the history is held at zero |
| sample_stb | input | 1 | One-cycle strobe marking a new sample |
| sample_in | input | DATA_W | Signed sample value |
| period_in | input | PER_W | Unsigned sample period, taken with the strobe |
| rate_out | output | DATA_W+3 | Signed quotient, held between results |
| rate_valid | output | 1 | One-cycle pulse when a new quotient is on rate_out |
| busy | output | 1 | Division in progress |
| overrun | output | 1 | Sticky flag: a strobe was dropped during a division |
| zero_err | output | 1 | The last accepted strobe carried a zero period |

## Verification
A new strobe can arrive in the same cycle that the divider is still working through an earlier sample. The bench provokes this by raising sample_stb a few cycles into a division, both in directed cases and in randomly chosen iterations. The collision is judged three ways: the earlier division must finish on its normal cycle with the correct quotient, overrun must rise and stay high, and the following result must match a history model in which the dropped sample never appeared.

// File: rtl/deriv_pkg.sv
package deriv_pkg;
   // scale applied to the period to form the divisor
   localparam int unsigned PERIOD_SCALE = 10;
   // growth of the weighted difference over the sample width
   localparam int unsigned NUM_GUARD    = 3;
   // bits added to the period width by the scale
   localparam int unsigned DEN_GUARD    = 4;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_t;
endpackage

// File: rtl/deriv_history.sv
module deriv_history
   import deriv_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned NUM_W = DATA_W + NUM_GUARD
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     shift,
   input  logic signed [DATA_W-1:0] sample,
   output logic signed [NUM_W-1:0]  num
);

   generate
      if (DEPTH != 4) begin : g_bad_depth
         $error("deriv_history: the weighted difference needs exactly four taps");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("deriv_history: DATA_W must be at least 2");
      end
   endgenerate

   // tap[0] is the live sample, tap[k] is the sample k periods back
   logic signed [DATA_W-1:0] tap [DEPTH];
   assign tap[0] = sample;

   genvar k;
   generate
      for (k = 1; k < DEPTH; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               tap[k] <= '0;
            end else if (shift) begin
               tap[k] <= tap[k-1];
            end
         end
      end
   endgenerate

   logic signed [NUM_W-1:0] e0, e1, e2, e3, d03;
   assign e0  = tap[0];
   assign e1  = tap[1];
   assign e2  = tap[2];
   assign e3  = tap[3];
   assign d03 = e0 - e3;
   assign num = d03 + (d03 <<< 1) + e1 - e2;

   // R5: a clear leaves every stored tap at zero
   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (tap[1] == '0 && tap[2] == '0 && tap[3] == '0));

   // R1: the newest stored tap is the sample captured at the shift
   assert_shift_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clear) |=> (tap[1] == $past(sample)));

endmodule

// File: rtl/deriv_sdiv.sv
module deriv_sdiv
   import deriv_pkg::*;
#(
   parameter int unsigned NUM_W = 19,
   parameter int unsigned DEN_W = 12,
   localparam int unsigned CNT_W = $clog2(NUM_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [NUM_W-1:0] num,
   input  logic        [DEN_W-1:0] den,
   output logic                    busy,
   output logic                    done,
   output logic signed [NUM_W-1:0] quo
);

   generate
      if (NUM_W < 2) begin : g_bad_num
         $error("deriv_sdiv: NUM_W must be at least 2");
      end
      if (DEN_W < 2) begin : g_bad_den
         $error("deriv_sdiv: DEN_W must be at least 2");
      end
   endgenerate

   div_state_t           state;
   logic [CNT_W-1:0]     cnt;
   logic [DEN_W-1:0]     rem;
   logic [DEN_W-1:0]     den_r;
   logic [NUM_W-1:0]     qsr;
   logic                 neg;

   logic [NUM_W-1:0]     mag;
   logic [DEN_W:0]       trial;
   logic                 ge;
   logic [DEN_W:0]       diff;
   logic [NUM_W-1:0]     qnext;

   assign mag   = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
   assign trial = {rem, qsr[NUM_W-1]};
   assign ge    = trial >= {1'b0, den_r};
   assign diff  = trial - {1'b0, den_r};
   assign qnext = {qsr[NUM_W-2:0], ge};
   assign busy  = (state == DIV_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= DIV_IDLE;
         cnt   <= '0;
         rem   <= '0;
         den_r <= '0;
         qsr   <= '0;
         neg   <= 1'b0;
         done  <= 1'b0;
         quo   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            DIV_IDLE: begin
               if (start) begin
                  state <= DIV_RUN;
                  cnt   <= '0;
                  rem   <= '0;
                  den_r <= den;
                  qsr   <= mag;
                  neg   <= num[NUM_W-1];
               end
            end
            DIV_RUN: begin
               qsr <= qnext;
               rem <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(NUM_W - 1)) begin
                  state <= DIV_IDLE;
                  done  <= 1'b1;
                  quo   <= neg ? -$signed(qnext) : $signed(qnext);
               end
            end
            default: state <= DIV_IDLE;
         endcase
      end
   end

   // R3: completion is a single-cycle pulse
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the quotient moves only together with the completion pulse
   assert_quo_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(quo)));

   // R3: a completion is always preceded by a busy cycle
   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R7: the divider is never started with a zero divisor
   assert_den_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (den != '0));

endmodule

// File: rtl/deriv_rate_top.sv
module deriv_rate_top
   import deriv_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PER_W  = 8,
   localparam int unsigned OUT_W = DATA_W + NUM_GUARD,
   localparam int unsigned DEN_W = PER_W + DEN_GUARD
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run,
   input  logic                     sample_stb,
   input  logic signed [DATA_W-1:0] sample_in,
   input  logic        [PER_W-1:0]  period_in,
   output logic signed [OUT_W-1:0]  rate_out,
   output logic                     rate_valid,
   output logic                     busy,
   output logic                     overrun,
   output logic                     zero_err
);

   generate
      if (PER_W < 1) begin : g_bad_per
         $error("deriv_rate_top: PER_W must be at least 1");
      end
   endgenerate

   logic                    accept;
   logic                    zero_p;
   logic                    collide;
   logic signed [OUT_W-1:0] num;
   logic        [DEN_W-1:0] den;

   assign accept  = run && sample_stb && !busy;
   assign collide = run && sample_stb && busy;
   assign zero_p  = (period_in == '0);
   assign den     = DEN_W'(period_in) * DEN_W'(PERIOD_SCALE);

   deriv_history #(
      .DATA_W (DATA_W),
      .DEPTH  (4)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!run),
      .shift  (accept),
      .sample (sample_in),
      .num    (num)
   );

   deriv_sdiv #(
      .NUM_W (OUT_W),
      .DEN_W (DEN_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && !zero_p),
      .num   (num),
      .den   (den),
      .busy  (busy),
      .done  (rate_valid),
      .quo   (rate_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         overrun  <= 1'b0;
         zero_err <= 1'b0;
      end else begin
         if (collide) overrun <= 1'b1;
         if (accept)  zero_err <= zero_p;
      end
   end

   // R4: with run low and the divider idle, no result can appear
   assert_run_low_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !busy) |=> !rate_valid);

   // R6: a strobe during a division raises overrun
   assert_collide_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sample_stb && busy) |=> overrun);

   // R6: overrun never falls outside reset
   assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7: a zero period flags an error and starts nothing
   assert_zero_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && zero_p) |=> (zero_err && !busy));

   // R3: a good strobe makes the divider busy on the next cycle
   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !zero_p) |=> busy);

endmodule

// File: tb/test_deriv_rate_top.sv
`timescale 1ns/1ps
module test_deriv_rate_top;
   localparam int DATA_W = 16;
   localparam int PER_W  = 8;
   localparam int OUT_W  = DATA_W + 3;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     run = 1'b0;
   logic                     sample_stb = 1'b0;
   logic signed [DATA_W-1:0] sample_in = '0;
   logic        [PER_W-1:0]  period_in = '0;
   logic signed [OUT_W-1:0]  rate_out;
   logic                     rate_valid;
   logic                     busy;
   logic                     overrun;
   logic                     zero_err;

   int errors = 0;
   int checks = 0;
   int m1 = 0, m2 = 0, m3 = 0;
   int last_q = 0;
   bit exp_ovr = 0;
   int unsigned seed_dummy;

   always #4 clk = ~clk;

   deriv_rate_top #(.DATA_W(DATA_W), .PER_W(PER_W)) i_deriv_rate_top (
      .clk(clk), .rst_n(rst_n), .run(run), .sample_stb(sample_stb),
      .sample_in(sample_in), .period_in(period_in), .rate_out(rate_out),
      .rate_valid(rate_valid), .busy(busy), .overrun(overrun),
      .zero_err(zero_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model_rate(input int x0, input int p);
      int n;
      n = 3 * (x0 - m3) + m1 - m2;
      return n / (10 * p);
   endfunction

   task automatic tick;
      @(posedge clk); #1;
   endtask

   // one strobe with run high; inj drops a second strobe into the division
   task automatic send(input int x, input int p, input bit inj);
      int k;
      int exp_q;
      bit seen;
      exp_q = (p != 0) ? model_rate(x, p) : last_q;
      sample_stb = 1'b1; sample_in = DATA_W'(x); period_in = PER_W'(p);
      tick();
      sample_stb = 1'b0;
      m3 = m2; m2 = m1; m1 = x;
      if (p == 0) begin
         check(zero_err == 1'b1, "R7 zero_err set", int'(zero_err), 1);
         check(busy == 1'b0, "R7 no division", int'(busy), 0);
         seen = 0;
         for (int i = 0; i < OUT_W + 4; i++) begin
            tick();
            if (rate_valid) seen = 1;
         end
         check(!seen, "R7 no valid", int'(seen), 0);
         check(int'(rate_out) == last_q, "R7 output held", int'(rate_out), last_q);
      end else begin
         check(zero_err == 1'b0, "R7 zero_err cleared", int'(zero_err), 0);
         check(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
         k = 0;
         seen = 0;
         while (!seen && k < OUT_W + 10) begin
            tick();
            k++;
            if (inj && k == 2) begin
               sample_stb = 1'b1; sample_in = DATA_W'(x + 1234);
            end
            if (inj && k == 3) begin
               sample_stb = 1'b0; exp_ovr = 1;
            end
            if (rate_valid) seen = 1;
         end
         check(k == OUT_W, "R3 latency", k, OUT_W);
         check(int'(rate_out) == exp_q, "R1 quotient", int'(rate_out), exp_q);
         tick();
         check(rate_valid == 1'b0, "R3 single pulse", int'(rate_valid), 0);
         last_q = exp_q;
      end
      check(overrun == exp_ovr, "R6 overrun flag", int'(overrun), int'(exp_ovr));
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_0042);
      tick(); tick();
      check(rate_out == '0, "R8 reset rate_out", int'(rate_out), 0);
      rst_n = 1'b1;
      tick();
      check(rate_valid == 1'b0, "R8 reset valid", int'(rate_valid), 0);
      check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
      check(overrun == 1'b0, "R8 reset overrun", int'(overrun), 0);
      check(zero_err == 1'b0, "R8 reset zero_err", int'(zero_err), 0);
      check(rate_out == '0, "R8 reset rate_out held", int'(rate_out), 0);

      // R5: first result from zero history, R2 truncation toward zero
      run = 1'b1; tick();
      send(-9, 1, 0);
      check(int'(rate_out) == -2, "R2 truncate toward zero", int'(rate_out), -2);
      send(32767, 1, 0);
      send(-32768, 3, 0);
      send(100, 255, 0);

      // R4: strobes ignored while run low, history cleared (R5)
      run = 1'b0; tick();
      m1 = 0; m2 = 0; m3 = 0;
      for (int i = 0; i < 3; i++) begin
         sample_stb = 1'b1; sample_in = DATA_W'(5000 + i); period_in = 8'd2;
         tick();
         sample_stb = 1'b0;
         check(busy == 1'b0, "R4 ignored no busy", int'(busy), 0);
         for (int j = 0; j < OUT_W + 2; j++) begin
            tick();
            check(rate_valid == 1'b0, "R4 no valid", int'(rate_valid), 0);
         end
         check(int'(rate_out) == last_q, "R4 output held", int'(rate_out), last_q);
      end
      run = 1'b1; tick();
      send(700, 2, 0);
      send(-300, 1, 0);
      send(1234, 5, 0);

      // R7: zero period still shifts history
      send(-2000, 0, 0);
      send(40, 4, 0);

      // R6: dropped strobe during a division
      send(321, 1, 1);
      send(-77, 2, 0);

      for (int it = 0; it < 80; it++) begin
         int x, p;
         bit inj;
         x = int'($signed(16'($urandom)));
         p = ($urandom % 8 == 0) ? 0 : int'($urandom % 256);
         inj = ($urandom % 6 == 0);
         if (p == 0) inj = 0;
         send(x, p, inj);
      end
      finish_run();
   end
endmodule